// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a two-wire bus protocol engine inside a small byte-wide storage device. The engine hands it a word address, then a stream of data bytes, then a pulse when the bus stop condition is seen. The block gathers the bytes in a one-page buffer. Each buffered byte carries its own valid flag. Write addresses wrap inside the current page. On the stop pulse, the block copies the flagged bytes into its internal synchronous array during a self-timed cycle of fixed length.

While that cycle runs, the block raises `busy`. The protocol engine uses this flag to withhold acknowledges, and the block ignores all of its own inputs until the cycle ends. The block also owns the word address counter. Reads advance the counter across the whole array, and the data for the current address is presented one clock after the address settles. A write-protect input, sampled at the stop pulse, throws the buffered bytes away instead of committing them.

Top module: `page_commit_seq`

## Requirements
- R1: After reset, `busy` is 0 and `addr_out` is 0.
- R2: A data strobe stores `wr_data` at the buffer slot given by the low log2(PAGE) address bits and increments only those bits; the upper address bits stay fixed. An address load discards any bytes still pending in the buffer.
- R3: When the in-page address passes the last byte of the page, the next byte goes to the first byte of the same page. A byte sent to a slot that already holds one replaces the earlier byte.
- R4: A stop pulse, with at least one byte pending and `wp` low, raises `busy` on the next clock. `busy` then stays high for exactly WR_CYCLES clocks.
- R5: A commit writes only the buffer slots whose valid flag is set. The other bytes of that page in the array keep their old values.
- R6: When `wp` is high at the stop pulse, the pending bytes are discarded, no write cycle starts, and the array is unchanged.
- R7: While `busy` is high, `addr_load`, `wr_byte`, `rd_next` and `stop_seen` have no effect.
- R8: Between operations, `addr_out` holds the address after the last one accessed. After a write this is the in-page successor; after a read it is the next array address.
- R9: `rd_data` shows the array byte at `addr_out` one clock after the address changes. `rd_next` advances the address by one, and the address wraps from DEPTH-1 to 0.
- R10: A stop pulse that follows an address load with no data bytes starts no write cycle.
- R11: A data strobe and a stop pulse in the same cycle are both accepted. The byte is included in the commit that the stop starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Pulse: load the word address counter from `addr_in` |
| addr_in | input | AW | Word address to load |
| wr_byte | input | 1 | Pulse: one received data byte is on `wr_data` |
| wr_data | input | 8 | Data byte to buffer |
| rd_next | input | 1 | Pulse: the current read byte was consumed; advance the address |
| stop_seen | input | 1 | Pulse: the bus stop condition was seen |
| wp | input | 1 | Write protect; high blocks array writes |
| busy | output | 1 | The self-timed write cycle is in progress |
| addr_out | output | AW | Current word address counter |
| rd_data | output | 8 | Array byte at the current address |

## Verification
The collision of interest is the last data strobe landing in the same clock as the stop pulse. The commit decision must then count the valid flag that the strobe is setting at that moment, not only the flags already stored. The bench drives `wr_byte` and `stop_seen` together on one edge into an otherwise empty buffer. It checks that `busy` rises on the next clock and that, once the cycle ends, the array holds that byte at its address. If the stop is resolved against the stale flags, `busy` stays low and the read-back returns old data.

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int DEPTH     = 256,
  parameter int PAGE      = 8,
  parameter int WR_CYCLES = 40,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE),
  localparam int CW = $clog2(WR_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_byte,
  input  logic [7:0]    wr_data,
  input  logic          rd_next,
  input  logic          stop_seen,
  input  logic          wp,
  output logic          busy,
  output logic [AW-1:0] addr_out,
  output logic [7:0]    rd_data
);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  vld, vld_nx;
  logic [AW-1:0]    addr_q;
  logic [AW-PW-1:0] row_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic [7:0]       rd_q;

  wire          take  = !busy_q;
  wire          ld    = take && addr_load;
  wire          wb    = take && wr_byte && !addr_load;
  wire          rn    = take && rd_next && !addr_load && !wr_byte;
  wire [PW-1:0] slot  = addr_q[PW-1:0];
  wire [PW-1:0] cslot = PW'(cnt_q);
  wire          last  = (int'(cnt_q) == WR_CYCLES - 1);

  assign vld_nx = ld ? '0 : (vld | (wb ? (PAGE'(1) << slot) : '0));

  wire go = take && stop_seen && (|vld_nx) && !wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      row_q  <= '0;
      vld    <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ld) begin
        addr_q <= addr_in;
        row_q  <= addr_in[AW-1:PW];
      end else if (wb) begin
        addr_q <= {addr_q[AW-1:PW], slot + PW'(1)};
        row_q  <= addr_q[AW-1:PW];
      end else if (rn) begin
        addr_q <= addr_q + AW'(1);
      end

      if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          vld    <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (stop_seen) begin
        vld    <= go ? vld_nx : '0;
        busy_q <= go;
        cnt_q  <= '0;
      end else begin
        vld <= vld_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb) pbuf[slot] <= wr_data;
    if (busy_q && int'(cnt_q) < PAGE && vld[cslot])
      mem[{row_q, cslot}] <= pbuf[cslot];
    rd_q <= mem[addr_q];
  end

  assign busy     = busy_q;
  assign addr_out = addr_q;
  assign rd_data  = rd_q;

  assert_commit_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stop_seen)) else $error("busy rose without stop");

  assert_cycle_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> int'(cnt_q) < WR_CYCLES) else $error("write cycle overran");

  assert_row_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])) else $error("page row moved on write");

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(addr_q)) else $error("address moved while busy");

  assert_read_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rn && addr_q == AW'(DEPTH - 1)) |=> addr_q == '0) else $error("read did not wrap");

  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && wp && !busy_q) |=> !busy_q) else $error("commit under write protect");

  assert_empty_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !busy_q && vld == '0 && !wr_byte) |=> !busy_q) else $error("commit with empty buffer");

endmodule

// File: tb/page_commit_seq_tb.sv
module page_commit_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  logic       clk = 0, rst_n = 0;
  logic       addr_load = 0, wr_byte = 0, rd_next = 0, stop_seen = 0, wp = 0;
  logic [7:0] addr_in = 0, wr_data = 0;
  logic       busy;
  logic [7:0] addr_out, rd_data;
  int checks = 0, errors = 0;

  page_commit_seq #(.DEPTH(256), .PAGE(8), .WR_CYCLES(W)) dut_i (
    .clk, .rst_n, .addr_load, .addr_in, .wr_byte, .wr_data, .rd_next,
    .stop_seen, .wp, .busy, .addr_out, .rd_data);

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_addr(input logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk); wr_byte = 1; wr_data = d;
    @(negedge clk); wr_byte = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_seen = 1;
    @(negedge clk); stop_seen = 0;
  endtask

  task automatic do_rdnext();
    @(negedge clk); rd_next = 1;
    @(negedge clk); rd_next = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    load_addr(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_cycle(string req);
    chk(req, busy, 1);
    repeat (W - 1) @(negedge clk);
    chk(req, busy, 1);
    @(negedge clk);
    chk(req, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 addr", addr_out, 0);
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    load_addr(8'h13); put_byte(8'hA5);
    chk("R8 addr after write", addr_out, 8'h14);
    do_stop(); check_cycle("R4 busy length");
    read_at(8'h13, d); chk("R2 stored byte", d, 8'hA5);
  endtask

  task automatic t_page_wrap();
    logic [7:0] d;
    load_addr(8'h2E);
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h44);
    chk("R3 R8 addr wrapped in page", addr_out, 8'h2A);
    do_stop(); wait_idle();
    read_at(8'h28, d); chk("R3 wrapped byte", d, 8'h33);
    read_at(8'h2F, d); chk("R3 last slot", d, 8'h22);
    read_at(8'h29, d); chk("R3 second wrapped", d, 8'h44);
    load_addr(8'h40);
    for (int i = 0; i < 9; i++) put_byte(8'(i));
    do_stop(); wait_idle();
    read_at(8'h40, d); chk("R3 overwrite", d, 8'h08);
    read_at(8'h41, d); chk("R3 untouched neighbour", d, 8'h01);
  endtask

  task automatic t_flagged_only();
    logic [7:0] d;
    load_addr(8'h50);
    for (int i = 0; i < 8; i++) put_byte(8'hC0 + 8'(i));
    do_stop(); wait_idle();
    load_addr(8'h53); put_byte(8'h77); do_stop(); wait_idle();
    read_at(8'h52, d); chk("R5 unflagged below", d, 8'hC2);
    read_at(8'h53, d); chk("R5 flagged", d, 8'h77);
    read_at(8'h54, d); chk("R5 unflagged above", d, 8'hC4);
  endtask

  task automatic t_write_protect();
    logic [7:0] d;
    wp = 1;
    load_addr(8'h53); put_byte(8'h99); do_stop();
    chk("R6 no busy under wp", busy, 0);
    wp = 0;
    do_stop();
    chk("R6 buffer discarded", busy, 0);
    read_at(8'h53, d); chk("R6 array unchanged", d, 8'h77);
  endtask

  task automatic t_empty_stop();
    load_addr(8'h60); do_stop();
    chk("R10 no commit without data", busy, 0);
  endtask

  task automatic t_ignore_busy();
    logic [7:0] d;
    load_addr(8'h70); put_byte(8'h5A); do_stop();
    load_addr(8'h10); put_byte(8'hEE); do_rdnext(); do_stop();
    wait_idle();
    chk("R7 addr held", addr_out, 8'h71);
    do_stop();
    chk("R7 strobe while busy dropped", busy, 0);
    read_at(8'h70, d); chk("R7 committed byte", d, 8'h5A);
  endtask

  task automatic t_seq_read();
    logic [7:0] d;
    load_addr(8'h00); put_byte(8'h3C); do_stop(); wait_idle();
    load_addr(8'hF8);
    for (int i = 0; i < 8; i++) put_byte(8'hB0 + 8'(i));
    do_stop(); wait_idle();
    read_at(8'hFE, d); chk("R9 read FE", d, 8'hB6);
    do_rdnext(); @(negedge clk);
    chk("R9 read FF", rd_data, 8'hB7);
    do_rdnext();
    chk("R9 R8 wrap to 0", addr_out, 8'h00);
    @(negedge clk);
    chk("R9 read after wrap", rd_data, 8'h3C);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    load_addr(8'h88);
    @(negedge clk); wr_byte = 1; wr_data = 8'h61; stop_seen = 1;
    @(negedge clk); wr_byte = 0; stop_seen = 0;
    check_cycle("R11 stop with byte");
    read_at(8'h88, d); chk("R11 byte committed", d, 8'h61);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_flagged_only();
    t_write_protect();
    t_empty_stop();
    t_ignore_busy();
    t_seq_read();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule